// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a synthesizable synchronous SRAM whose data bus never needs an idle cycle when traffic switches between reads and writes. All commands (address, read/write select, byte enables, chip enables and burst advance) are taken on the rising clock edge. A static strap, `ft_mode`, picks the read timing. In flow-through mode, read data comes straight from the array during the cycle after the command. In pipelined mode, read data passes through an output register and appears one cycle later.

Writes are late. The write data bus is sampled one edge after the command in flow-through mode and two edges after it in pipelined mode. Because of this, a write slot lines up with the slot a read would use, and commands can alternate freely. Each word holds four 9-bit bytes, and each byte has its own write enable. A burst of four beats can run from a single command, in either wrapping linear order or XOR order. Output enable and sleep gate the output drive combinationally.

Top module: `nbt_sram`

## Requirements
- R1: With `ft_mode`=1, a read accepted at edge n drives `dq_en`=1 and `dout`=the word during the cycle between edges n and n+1.
- R2: With `ft_mode`=0, a read accepted at edge n drives `dq_en`=1 and `dout` during the cycle between edges n+1 and n+2, and not before.
- R3: A write (`we_n`=0) accepted at edge n stores the `din` value sampled at edge n+1 (`ft_mode`=1) or at edge n+2 (`ft_mode`=0).
- R4: Reads and writes may alternate on consecutive edges with no idle cycle, and every read returns correct data.
- R5: `bw_n[i]`=0 writes byte i, which is bits 9i+8..9i. Bytes whose `bw_n` bit is 1 keep their old value.
- R6: A command starts only if `ce0_n`=0, `ce1`=1 and `ce2_n`=0 while `adv`=0. Otherwise the edge is a deselect: no access takes place and no read data is driven for it.
- R7: With `adv`=1 during an active burst, each beat uses the next address. With `ilv_order`=0, the two low address bits are (start+k) mod 4 for beat k, and the upper bits stay the same. The burst keeps the read/write direction of its starting command.
- R8: With `ilv_order`=1, the two low bits of beat k are start XOR k.
- R9: `oe_n`=1 forces `dq_en`=0 and `dout`=0 at once, within the same cycle, without waiting for a clock edge.
- R10: `sleep`=1 forces `dq_en`=0 and `dout`=0 at once. Any command or `adv` presented while it is high is ignored, and an active burst ends.
- R11: A read whose address matches a write whose data is still outstanding returns that data, merged byte by byte according to the write's enables.
- R12: While `rst_n`=0 and after it is released, `dq_en` stays 0 until a read is issued. The array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| ft_mode | input | 1 | Strap: 1 flow-through, 0 pipelined |
| ilv_order | input | 1 | Strap: 0 linear burst, 1 XOR burst |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Burst advance |
| we_n | input | 1 | 0 write, 1 read |
| addr | input | AW | Word address |
| bw_n | input | NB | Byte write enables, active low |
| din | input | NB*BB | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep |
| dout | output | NB*BB | Read data, zero when not driven |
| dq_en | output | 1 | Read data bus drive enable |

## Verification
In pipelined mode, a read can capture its word on the same edge that an earlier write to that address commits its late data. This collision is forced by issuing a write and then, on the very next edge, a read of the same address, with partial byte enables and with both orders of read and write. The behavioural model in the bench answers every read from its own array only after it has applied every earlier write. Any stale byte therefore shows up as a `dout` mismatch in the cycle where the read data is driven. The same pattern is repeated in flow-through mode, where the write lands one edge ahead of the read.

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BB = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ft_mode,
  input  logic               ilv_order,
  input  logic               ce0_n,
  input  logic               ce1,
  input  logic               ce2_n,
  input  logic               adv,
  input  logic               we_n,
  input  logic [AW-1:0]      addr,
  input  logic [NB-1:0]      bw_n,
  input  logic [NB*BB-1:0]   din,
  input  logic               oe_n,
  input  logic               sleep,
  output logic [NB*BB-1:0]   dout,
  output logic               dq_en
);
  localparam int DW = NB * BB;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          b_on, b_we;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  logic          a1_v, a1_we, a2_v, a2_we, q_v;
  logic [AW-1:0] a1_addr, a2_addr;
  logic [NB-1:0] a1_bw, a2_bw;
  logic [DW-1:0] q_d, fwd;

  wire sel  = !sleep && !adv && !ce0_n && ce1 && !ce2_n;
  wire cont = !sleep && adv && b_on;
  wire [1:0] nxt = b_cnt + 2'd1;
  wire [1:0] lo  = ilv_order ? (b_base[1:0] ^ nxt) : (b_base[1:0] + nxt);
  wire [AW-1:0] cmd_addr = sel ? addr : {b_base[AW-1:2], lo};
  wire cmd_v  = sel || cont;
  wire cmd_we = sel ? !we_n : b_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_on <= 1'b0;
      a1_v <= 1'b0;
      a2_v <= 1'b0;
      q_v  <= 1'b0;
    end else begin
      b_on <= sel || cont;
      a1_v <= cmd_v;
      a2_v <= a1_v;
      q_v  <= a1_v && !a1_we;
    end
  end

  always_ff @(posedge clk) begin
    if (sel) begin
      b_base <= addr;
      b_cnt  <= 2'd0;
      b_we   <= !we_n;
    end else if (cont) begin
      b_cnt  <= nxt;
    end
    a1_we   <= cmd_we;
    a1_addr <= cmd_addr;
    a1_bw   <= bw_n;
    a2_we   <= a1_we;
    a2_addr <= a1_addr;
    a2_bw   <= a1_bw;
    q_d     <= fwd;
  end

  wire          wr_v    = ft_mode ? (a1_v && a1_we) : (a2_v && a2_we);
  wire [AW-1:0] wr_addr = ft_mode ? a1_addr : a2_addr;
  wire [NB-1:0] wr_bw   = ft_mode ? a1_bw : a2_bw;

  always_ff @(posedge clk) begin
    if (wr_v)
      for (int i = 0; i < NB; i++)
        if (!wr_bw[i]) mem[wr_addr][i*BB +: BB] <= din[i*BB +: BB];
  end

  wire hit = a2_v && a2_we && (a2_addr == a1_addr);

  always_comb begin
    fwd = mem[a1_addr];
    for (int i = 0; i < NB; i++)
      if (hit && !a2_bw[i]) fwd[i*BB +: BB] = din[i*BB +: BB];
  end

  wire          rd_live = ft_mode ? (a1_v && !a1_we) : q_v;
  wire [DW-1:0] rd_data = ft_mode ? mem[a1_addr] : q_d;

  assign dq_en = rd_live && !oe_n && !sleep;
  assign dout  = dq_en ? rd_data : '0;
endmodule

module nbt_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic ft_mode,
  input logic ce0_n,
  input logic ce1,
  input logic ce2_n,
  input logic adv,
  input logic we_n,
  input logic oe_n,
  input logic sleep,
  input logic dq_en
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  wire start    = !sleep && !adv && !ce0_n && ce1 && !ce2_n;
  wire rd_start = start && we_n;
  wire wr_start = start && !we_n;
  wire idle     = sleep || (!adv && !start);

  // R1
  ft_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && ft_mode && $past(rd_start) && !oe_n && !sleep) |-> dq_en);
  // R2
  pl_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !ft_mode && $past(rd_start, 2) && !oe_n && !sleep) |-> dq_en);
  // R2
  pl_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !ft_mode && $past(wr_start, 2)) |-> !dq_en);
  // R4
  ft_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && ft_mode && $past(wr_start)) |-> !dq_en);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(idle) && $past(idle, 2)) |-> !dq_en);
endmodule

bind nbt_sram nbt_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ft_mode(ft_mode), .ce0_n(ce0_n), .ce1(ce1),
  .ce2_n(ce2_n), .adv(adv), .we_n(we_n), .oe_n(oe_n), .sleep(sleep),
  .dq_en(dq_en)
);

// File: tb/nbt_sram_tb.sv
`timescale 1ns/1ps
module nbt_sram_tb;
  localparam int AW = 6, NB = 4, BB = 9, DW = NB * BB, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, ft_mode = 1, ilv_order = 0;
  logic ce0_n = 1, ce1 = 0, ce2_n = 1, adv = 0, we_n = 1, oe_n = 0, sleep = 0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bw_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dq_en;

  always #5 clk = ~clk;

  nbt_sram #(.AW(AW), .NB(NB), .BB(BB)) u_dut (
    .clk(clk), .rst_n(rst_n), .ft_mode(ft_mode), .ilv_order(ilv_order),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .adv(adv), .we_n(we_n),
    .addr(addr), .bw_n(bw_n), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dq_en(dq_en));

  // behavioural reference
  logic [DW-1:0] mem_m [DEPTH];
  int wl[$], wa[$], rl[$], ra[$];
  logic [NB-1:0] wb[$];
  bit out_v = 0;
  logic [DW-1:0] out_d = '0;
  bit m_on = 0, m_we = 0;
  int m_base = 0, m_k = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      wl.delete(); wa.delete(); wb.delete(); rl.delete(); ra.delete();
      out_v = 0; m_on = 0;
    end else begin
      int k;
      bit s, c, cw;
      int ca;
      k = 0;
      while (k < wl.size()) begin
        wl[k]--;
        if (wl[k] == 0) begin
          for (int b = 0; b < NB; b++)
            if (!wb[k][b]) mem_m[wa[k]][b*BB +: BB] = din[b*BB +: BB];
          wl.delete(k); wa.delete(k); wb.delete(k);
        end else k++;
      end
      out_v = 0;
      k = 0;
      while (k < rl.size()) begin
        rl[k]--;
        if (rl[k] == 0) begin
          out_v = 1; out_d = mem_m[ra[k]];
          rl.delete(k); ra.delete(k);
        end else k++;
      end
      s = !sleep && !adv && !ce0_n && ce1 && !ce2_n;
      c = !sleep && adv && m_on;
      ca = 0; cw = 0;
      if (s) begin
        ca = int'(addr); cw = !we_n;
        m_base = int'(addr); m_k = 0; m_we = !we_n;
      end else if (c) begin
        m_k = (m_k + 1) % 4;
        ca = (m_base & ~3) | (ilv_order ? ((m_base & 3) ^ m_k) : (((m_base & 3) + m_k) % 4));
        cw = m_we;
      end
      m_on = s || c;
      if (s || c) begin
        if (cw) begin
          wl.push_back(ft_mode ? 1 : 2); wa.push_back(ca); wb.push_back(bw_n);
        end else if (ft_mode) begin
          out_v = 1; out_d = mem_m[ca];
        end else begin
          rl.push_back(1); ra.push_back(ca);
        end
      end
    end
  end

  int checks = 0, fails = 0;
  string req = "R12";

  task automatic check();
    bit en_x;
    logic [DW-1:0] d_x;
    en_x = out_v && !oe_n && !sleep && rst_n;
    d_x = en_x ? out_d : '0;
    checks++;
    if (dq_en !== en_x || dout !== d_x) begin
      fails++;
      $display("FAIL %s: dq_en=%0b dout=%h expected dq_en=%0b dout=%h",
               req, dq_en, dout, en_x, d_x);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check();
    din = {4'($urandom), 32'($urandom)};
  endtask

  task automatic raw(input logic c0n, input logic c1, input logic c2n,
                     input logic a_dv, input logic wn, input int a,
                     input logic [NB-1:0] bw);
    tick();
    ce0_n = c0n; ce1 = c1; ce2_n = c2n; adv = a_dv; we_n = wn;
    addr = AW'(a); bw_n = bw;
  endtask

  task automatic wr(input int a, input logic [NB-1:0] bw);
    raw(0, 1, 0, 0, 0, a, bw);
  endtask
  task automatic rd(input int a);
    raw(0, 1, 0, 0, 1, a, '1);
  endtask
  task automatic nop();
    raw(1, 0, 1, 0, 1, 0, '1);
  endtask
  task automatic step();
    raw(1, 0, 1, 1, 1, 0, '1);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) nop();
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog: expired, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R12 reset
    idle(3);
    rst_n = 1;
    idle(2);

    // R3 fill in flow-through mode
    req = "R3";
    for (int a = 0; a < DEPTH; a++) wr(a, '0);
    idle(2);

    // R1 flow-through reads
    req = "R1";
    for (int a = 0; a < 8; a++) rd(a * 7 % DEPTH);
    idle(2);

    // R4 and R11 alternation, flow-through
    req = "R4";
    for (int i = 0; i < 6; i++) begin wr(10 + i % 2, 4'b0000); rd(10 + i % 2); end
    idle(2);
    req = "R11";
    wr(12, 4'b0101); rd(12); rd(12); wr(12, 4'b1110); rd(12);
    idle(2);

    // R5 byte enables
    req = "R5";
    wr(20, 4'b1010); wr(21, 4'b0111); wr(22, 4'b1111); rd(20); rd(21); rd(22);
    idle(2);

    // R2 pipelined
    ft_mode = 0;
    idle(3);
    req = "R2";
    for (int a = 0; a < 8; a++) rd(a * 5 % DEPTH);
    rd(3); nop(); rd(4); nop(); nop();
    idle(2);
    req = "R3";
    wr(30, 4'b0000); nop(); nop(); rd(30); wr(31, 4'b0000); nop(); rd(31);
    idle(3);

    // R11 and R4 pipelined collisions
    req = "R11";
    wr(33, 4'b0000); rd(33); wr(33, 4'b1001); rd(33); wr(34, 4'b0110); rd(34); rd(33);
    idle(3);
    req = "R4";
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) wr(40 + i % 3, 4'b0000); else rd(40 + i % 3);
    end
    rd(40); wr(41, 4'b0011); rd(41); wr(40, 4'b1100); rd(40);
    idle(3);
    req = "R5";
    wr(44, 4'b0110); rd(44); wr(44, 4'b1101); nop(); rd(44);
    idle(3);

    // R6 chip enables, each one off
    req = "R6";
    raw(1, 1, 0, 0, 0, 33, '0); raw(0, 0, 0, 0, 0, 33, '0); raw(0, 1, 1, 0, 0, 33, '0);
    raw(1, 1, 0, 0, 1, 33, '1); raw(0, 0, 0, 0, 1, 34, '1); raw(0, 1, 1, 0, 1, 34, '1);
    nop(); nop(); rd(33); rd(34);
    idle(3);

    // R7 linear bursts
    req = "R7";
    ilv_order = 0;
    rd(6); step(); step(); step(); step(); step();
    idle(3);
    wr(49, 4'b0000); step(); step(); step(); rd(48); rd(49); rd(50); rd(51);
    idle(3);

    // R8 interleaved bursts, flow-through
    ft_mode = 1;
    idle(3);
    req = "R8";
    ilv_order = 1;
    rd(9); step(); step(); step();
    idle(2);
    wr(58, 4'b0000); step(); step(); step(); rd(56); rd(57); rd(58); rd(59);
    idle(2);
    req = "R7";
    ilv_order = 0;
    rd(14); step(); step(); step(); nop(); step();
    idle(2);

    // R9 output enable
    req = "R9";
    rd(1); rd(2);
    @(negedge clk); check();
    oe_n = 1; #1 check();
    oe_n = 0; #1 check();
    din = '0;
    ce0_n = 1; ce1 = 0; ce2_n = 1; adv = 0;
    oe_n = 1; rd(3); rd(4); oe_n = 0; rd(5); idle(2);

    // R10 sleep, pipelined
    ft_mode = 0;
    idle(3);
    req = "R10";
    rd(7); sleep = 1; nop(); check(); sleep = 0;
    idle(2);
    sleep = 1; wr(7, '0); rd(7); nop(); nop(); sleep = 0;
    rd(7); step(); step(); nop(); nop();
    rd(16); sleep = 1; step(); sleep = 0; step(); nop(); nop();
    idle(3);

    // R12 reset mid-traffic
    req = "R12";
    rd(2); rd(3); rst_n = 0; idle(2); rst_n = 1; idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule